// File: doc/BRIEF.md
# Comparator Change Interrupt and Wake Controller

This block is the digital wrapper around an analog comparator in a small microcontroller. The comparator output arrives as an asynchronous level. The block brings it into the clock domain and reports its current state as a readable status bit. Every transition of that level, rising or falling, sets a sticky event flag. From the flag, a set of enable bits, the global interrupt enable and the core's sleep state, the block forms three registered requests: an interrupt request, a wake-up request and a "take the vector" request. It also presents the fixed vector address 0x00F.

A two-bit mode field picks how the analog part is used. The code 2'b11 selects operational-amplifier use. In that mode the change logic is silent and none of the requests can be raised. Any other code selects comparator use. While the core sleeps with wake-up enabled, a change asks the core to wake. The global interrupt enable then decides what happens next: with it clear, the core resumes at the next instruction; with it set, the core takes the vector.

Top module: `cmp_wake_ctrl`

## Requirements
- R1: `cmpout` shows the comparator level after a two-flop synchroniser: a change of `cmp_async` that is set up before rising edge k appears on `cmpout` after edge k+1.
- R2: In comparator mode (`mode` not equal to 2'b11), every change of `cmp_async`, rising or falling, sets `flag` at edge k+2, where edge k is the first edge after the change.
- R3: `flag` is sticky. It stays at 1 until a cycle with `flag_clr` = 1, and it reads 0 after that edge if no new change is being set in the same cycle.
- R4: When a change sets the flag in the same cycle that `flag_clr` is 1, the flag stays 1.
- R5: With `mode` = 2'b11, changes do not set `flag`, and `irq`, `wake` and `vector_take` are 0 one edge later, whatever the enables and the flag are. When comparator mode is selected again with `cmp_async` unchanged, no flag is set.
- R6: `irq` is registered and equals, one edge later, comparator mode AND `flag` AND `int_en` AND `gie`.
- R7: `wake` is registered and equals, one edge later, comparator mode AND `flag` AND `wake_en` AND `sleep`.
- R8: `vector_take` is registered and equals, one edge later, comparator mode AND `flag` AND `int_en` AND `gie` AND NOT `sleep`. So a wake-up with `gie` = 0 resumes the core without a vector, and with `gie` = 1 the vector is taken once `sleep` drops.
- R9: `vec_addr` is always 12'h00F.
- R10: While `rst` (synchronous, active high) is 1, `flag`, `irq`, `wake` and `vector_take` read 0. A level on `cmp_async` that stays stable through reset does not set the flag afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_async | input | 1 | Raw comparator output, asynchronous |
| mode | input | 2 | Use select; 2'b11 is op-amp use, other codes are comparator use |
| int_en | input | 1 | Comparator interrupt enable |
| wake_en | input | 1 | Wake-from-sleep enable |
| gie | input | 1 | Global interrupt enable of the core |
| sleep | input | 1 | Core is in sleep |
| flag_clr | input | 1 | Software clear of the event flag |
| cmpout | output | 1 | Synchronised comparator level |
| flag | output | 1 | Sticky change flag |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |
| vector_take | output | 1 | Core must enter the vector |
| vec_addr | output | 12 | Interrupt vector address |

## Verification
The bench aims at falling transitions as well as rising ones, since a design that detects one edge only would leave the flag low after a high-to-low change. It drives a clear in the exact cycle a change is being registered; a design where the clear wins would lose that event. It goes in and out of op-amp mode with the flag already set and with the input moved while in op-amp mode. A design that leaks the flag into the requests, or keeps a stale delayed copy, would then raise irq in op-amp mode or report a false change when comparator mode returns. Sleep is tested with the global enable clear and then set: a design that ignores sleep when it forms vector_take would send a sleeping core to the vector too early, or never send a woken one there.

// File: rtl/cmp_wake_pkg.sv
package cmp_wake_pkg;

  typedef enum logic [1:0] {
    MODE_CMP_A = 2'b00,
    MODE_CMP_B = 2'b01,
    MODE_CMP_C = 2'b10,
    MODE_OPAMP = 2'b11
  } cmp_mode_e;

  function automatic logic mode_is_comparator(input logic [1:0] m);
    return m != MODE_OPAMP;
  endfunction

endpackage

// File: rtl/cmp_sync.sv
// Multi-stage synchroniser for one asynchronous level.
// The chain is not reset, so it keeps sampling during reset
// and holds the true level when reset is released.
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/cmp_change_flag.sv
// Change detector and sticky event flag.
module cmp_change_flag (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic cmp_sel,
  input  logic clr,
  output logic chg,
  output logic flag
);

  logic lvl_d;

  // Delayed copy follows the level in every state (reset and
  // op-amp included), so it never lags when detection resumes.
  always_ff @(posedge clk) begin
    lvl_d <= lvl;
  end

  assign chg = cmp_sel & ~rst & (lvl ^ lvl_d);

  // Set takes priority over the software clear.
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (chg) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assert_set_on_change_R2: assert property (@(posedge clk) disable iff (rst)
    chg |=> flag);

  assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    flag && !clr |=> flag);

  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    flag && clr && !chg |=> !flag);

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    chg && clr |=> flag);

  assert_opamp_no_set_R5: assert property (@(posedge clk) disable iff (rst)
    !cmp_sel && !flag |=> !flag);

endmodule

// File: rtl/cmp_req_gen.sv
// Registered request generation from the flag and the enables.
module cmp_req_gen (
  input  logic clk,
  input  logic rst,
  input  logic flag,
  input  logic cmp_sel,
  input  logic int_en,
  input  logic wake_en,
  input  logic gie,
  input  logic sleep,
  output logic irq,
  output logic wake,
  output logic vector_take
);

  logic live;
  logic irq_ok;

  assign live   = flag & cmp_sel;
  assign irq_ok = live & int_en & gie;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq         <= 1'b0;
      wake        <= 1'b0;
      vector_take <= 1'b0;
    end else begin
      irq         <= irq_ok;
      wake        <= live & wake_en & sleep;
      vector_take <= irq_ok & ~sleep;
    end
  end

  assert_opamp_silent_R5: assert property (@(posedge clk) disable iff (rst)
    !cmp_sel |=> !irq && !wake && !vector_take);

  assert_irq_needs_enables_R6: assert property (@(posedge clk) disable iff (rst)
    !(int_en && gie) |=> !irq);

  assert_wake_needs_sleep_R7: assert property (@(posedge clk) disable iff (rst)
    !(sleep && wake_en) |=> !wake);

  assert_no_vector_asleep_R8: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !vector_take);

endmodule

// File: rtl/cmp_wake_ctrl.sv
module cmp_wake_ctrl
  import cmp_wake_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter int              VEC_W       = 12,
  parameter logic [VEC_W-1:0] VEC_ADDR   = 12'h00F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_async,
  input  logic [1:0]       mode,
  input  logic             int_en,
  input  logic             wake_en,
  input  logic             gie,
  input  logic             sleep,
  input  logic             flag_clr,
  output logic             cmpout,
  output logic             flag,
  output logic             irq,
  output logic             wake,
  output logic             vector_take,
  output logic [VEC_W-1:0] vec_addr
);

  logic lvl_sync;
  logic cmp_sel;
  logic chg;

  assign cmp_sel = mode_is_comparator(mode);

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .din  (cmp_async),
    .dout (lvl_sync)
  );

  cmp_change_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .lvl     (lvl_sync),
    .cmp_sel (cmp_sel),
    .clr     (flag_clr),
    .chg     (chg),
    .flag    (flag)
  );

  cmp_req_gen u_req (
    .clk         (clk),
    .rst         (rst),
    .flag        (flag),
    .cmp_sel     (cmp_sel),
    .int_en      (int_en),
    .wake_en     (wake_en),
    .gie         (gie),
    .sleep       (sleep),
    .irq         (irq),
    .wake        (wake),
    .vector_take (vector_take)
  );

  assign cmpout   = lvl_sync;
  assign vec_addr = VEC_ADDR;

  assert_vector_implies_irq_R8: assert property (@(posedge clk) disable iff (rst)
    vector_take |-> irq);

  assert_change_only_in_cmp_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OPAMP) |-> !chg);

endmodule

// File: tb/cmp_wake_ctrl_tb_top.sv
module cmp_wake_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SEED       = 20240517;
  localparam int RAND_CYC   = 4000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst = 1'b1, cmp_async = 1'b1, int_en = 1'b0, wake_en = 1'b0;
  logic gie = 1'b0, sleep = 1'b0, flag_clr = 1'b0;
  logic [1:0] mode = 2'b00;
  logic cmpout, flag, irq, wake, vector_take;
  logic [11:0] vec_addr;

  cmp_wake_ctrl dut_i (
    .clk(clk), .rst(rst), .cmp_async(cmp_async), .mode(mode),
    .int_en(int_en), .wake_en(wake_en), .gie(gie), .sleep(sleep),
    .flag_clr(flag_clr), .cmpout(cmpout), .flag(flag), .irq(irq),
    .wake(wake), .vector_take(vector_take), .vec_addr(vec_addr)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Reference model built from the requirement timing.
  logic m_s1 = 1'b0, m_s2 = 1'b0, m_d = 1'b0;
  logic m_flag = 1'b0, m_irq = 1'b0, m_wake = 1'b0, m_vec = 1'b0;

  function automatic logic f_cmp(input logic [1:0] md);
    return md != 2'b11;
  endfunction
  function automatic logic f_irq(input logic f, input logic [1:0] md, input logic ie, input logic g);
    return f_cmp(md) & f & ie & g;
  endfunction
  function automatic logic f_wake(input logic f, input logic [1:0] md, input logic we, input logic sl);
    return f_cmp(md) & f & we & sl;
  endfunction
  function automatic logic f_vec(input logic f, input logic [1:0] md, input logic ie, input logic g, input logic sl);
    return f_irq(f, md, ie, g) & ~sl;
  endfunction

  always @(posedge clk) begin
    m_s1 <= cmp_async;
    m_s2 <= m_s1;
    m_d  <= m_s2;
    if (rst) begin
      m_flag <= 1'b0; m_irq <= 1'b0; m_wake <= 1'b0; m_vec <= 1'b0;
    end else begin
      if (f_cmp(mode) && (m_s2 != m_d)) m_flag <= 1'b1;
      else if (flag_clr)                m_flag <= 1'b0;
      m_irq  <= f_irq(m_flag, mode, int_en, gie);
      m_wake <= f_wake(m_flag, mode, wake_en, sleep);
      m_vec  <= f_vec(m_flag, mode, int_en, gie, sleep);
    end
  end

  task automatic chk(input string req, input string what, input logic [11:0] act, input logic [11:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R1", "cmpout", {11'd0, cmpout}, {11'd0, m_s2});
    chk("R2", "flag", {11'd0, flag}, {11'd0, m_flag});
    chk("R6", "irq", {11'd0, irq}, {11'd0, m_irq});
    chk("R7", "wake", {11'd0, wake}, {11'd0, m_wake});
    chk("R8", "vector_take", {11'd0, vector_take}, {11'd0, m_vec});
    chk("R9", "vec_addr", vec_addr, 12'h00F);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; step(); flag_clr = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    // R10: reset with a stable high input
    repeat (5) step();
    chk("R10", "flag in reset", {11'd0, flag}, 12'd0);
    chk("R10", "irq in reset", {11'd0, irq}, 12'd0);
    rst = 1'b0;
    repeat (6) step();
    chk("R10", "no flag after reset", {11'd0, flag}, 12'd0);

    // R1, R2 falling change
    cmp_async = 1'b0;
    step(); step();
    chk("R1", "cmpout after two edges", {11'd0, cmpout}, 12'd0);
    chk("R2", "flag not yet", {11'd0, flag}, 12'd0);
    step();
    chk("R2", "flag on falling change", {11'd0, flag}, 12'd1);
    // R3 sticky then clear
    repeat (4) step();
    chk("R3", "flag sticky", {11'd0, flag}, 12'd1);
    clear_flag();
    chk("R3", "flag cleared", {11'd0, flag}, 12'd0);

    // R2 rising change
    cmp_async = 1'b1;
    repeat (3) step();
    chk("R2", "flag on rising change", {11'd0, flag}, 12'd1);

    // R4 set and clear in the same cycle
    cmp_async = 1'b0;
    step(); step();
    flag_clr = 1'b1; step(); flag_clr = 1'b0;
    chk("R4", "set wins over clear", {11'd0, flag}, 12'd1);
    clear_flag();

    // R6, R8 run-mode interrupt
    int_en = 1'b1; gie = 1'b1;
    cmp_async = 1'b1;
    repeat (4) step();
    chk("R6", "irq raised", {11'd0, irq}, 12'd1);
    chk("R8", "vector in run mode", {11'd0, vector_take}, 12'd1);
    int_en = 1'b0; step();
    chk("R6", "irq masked by int_en", {11'd0, irq}, 12'd0);
    int_en = 1'b1; step();
    clear_flag(); step();
    chk("R6", "irq drops after clear", {11'd0, irq}, 12'd0);

    // R5 op-amp mode
    wake_en = 1'b1;
    cmp_async = 1'b0;
    repeat (4) step();
    chk("R6", "irq before op-amp", {11'd0, irq}, 12'd1);
    mode = 2'b11; step();
    chk("R5", "irq silent in op-amp", {11'd0, irq}, 12'd0);
    chk("R5", "vector silent in op-amp", {11'd0, vector_take}, 12'd0);
    clear_flag();
    cmp_async = 1'b1;
    repeat (5) step();
    chk("R5", "no flag in op-amp", {11'd0, flag}, 12'd0);
    chk("R1", "level readable in op-amp", {11'd0, cmpout}, 12'd1);
    sleep = 1'b1; step();
    chk("R5", "wake silent in op-amp", {11'd0, wake}, 12'd0);
    sleep = 1'b0;
    mode = 2'b01;
    repeat (4) step();
    chk("R5", "no false change on return", {11'd0, flag}, 12'd0);

    // R7, R8 sleep with gie clear: resume without vector
    gie = 1'b0; sleep = 1'b1;
    cmp_async = 1'b0;
    repeat (4) step();
    chk("R7", "wake in sleep", {11'd0, wake}, 12'd1);
    chk("R6", "no irq with gie clear", {11'd0, irq}, 12'd0);
    chk("R8", "no vector asleep", {11'd0, vector_take}, 12'd0);
    sleep = 1'b0; step();
    chk("R7", "wake drops when awake", {11'd0, wake}, 12'd0);
    chk("R8", "resume without vector", {11'd0, vector_take}, 12'd0);
    gie = 1'b1; step();
    chk("R8", "vector once gie set", {11'd0, vector_take}, 12'd1);
    sleep = 1'b1; step();
    chk("R8", "vector held off in sleep", {11'd0, vector_take}, 12'd0);
    chk("R7", "wake with gie set", {11'd0, wake}, 12'd1);
    sleep = 1'b0; step();
    chk("R8", "vector after wake", {11'd0, vector_take}, 12'd1);

    // R7 wake disabled
    clear_flag(); wake_en = 1'b0; sleep = 1'b1;
    cmp_async = 1'b1;
    repeat (4) step();
    chk("R7", "no wake without enable", {11'd0, wake}, 12'd0);
    sleep = 1'b0;

    // Random phase, checked against the model every cycle
    void'($urandom(SEED));
    for (int i = 0; i < RAND_CYC; i++) begin
      if ($urandom_range(5, 0) == 0) cmp_async = ~cmp_async;
      if ($urandom_range(19, 0) == 0)
        mode = ($urandom_range(3, 0) == 0) ? 2'b11 : 2'($urandom_range(2, 0));
      flag_clr = ($urandom_range(7, 0) == 0);
      if ($urandom_range(9, 0) == 0) int_en  = ~int_en;
      if ($urandom_range(9, 0) == 0) gie     = ~gie;
      if ($urandom_range(9, 0) == 0) wake_en = ~wake_en;
      if ($urandom_range(9, 0) == 0) sleep   = ~sleep;
      rst = ($urandom_range(499, 0) == 0);
      step();
      if (rst) chk("R10", "flag after reset edge", {11'd0, flag}, 12'd0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule